// File: doc/BRIEF.md
# Receive Descriptor Fill Engine

This block moves one incoming frame at a time from a byte stream into receive buffers in memory. The stream carries the payload only. The engine computes a CRC-32 over the payload and appends it after the last payload byte, so the frame length seen by software is the payload length plus four. Each buffer is described by a two-word descriptor in a ring. Word 0 holds the status flags and the length. Word 1 holds the byte address of the buffer. The engine fills buffers one after another. A buffer takes no more bytes than the configured maximum buffer size. When a buffer is closed, its word 0 is written back with the byte count and the ownership (empty) bit cleared.

Two length limits apply. A hard truncation limit cuts the frame short. A soft limit, taken from the upper half of the receive control word, only flags the frame. An optional two-byte zero pad at the head of the first buffer aligns the payload that follows it.

A receive-active flag tells the stream side whether a frame may enter. Software pulses a kick input after it hands buffers back. After each completed frame, the engine looks at the next descriptor itself.

Top module: `rx_bd_fill`

## Requirements
- R1: After reset, rx_active_o, s_ready_o, dsc_re_o, dsc_we_o, buf_we_o, irq_rxb_o and irq_rxf_o are all low, and the ring index is 0.
- R2: A pulse on rx_kick_i while idle reads word 0 of the current descriptor and sets rx_active_o to that word's empty bit (bit 15).
- R3: While rx_active_o is low and the engine is idle, s_ready_o stays low, so the stream is held off.
- R4: Each buffer receives min(bytes remaining, max_buf_i) bytes. The bytes go to consecutive byte addresses starting at the address in word 1 (at ring_base_i + 8*index + 4). Word 0 sits at ring_base_i + 8*index.
- R5: The CRC-32 is computed over the payload bytes only, including any bytes discarded by truncation. It uses the reflected polynomial 0xEDB88320, a register seeded with all ones and a complemented result, and it is appended most significant byte first. Its bytes may split across two buffers.
- R6: Each write-back puts the byte count in bits [31:16] and clears the empty bit (15). It keeps the wrap bit (13). It sets the last bit (11) only on the final buffer of a frame, and it clears stale last, length-violation and truncated bits.
- R7: Each write-back of word 0 coincides with exactly one single-cycle pulse. The pulse is irq_rxf_o on the final buffer and irq_rxb_o on the others.
- R8: When the frame length (pad + payload + 4) exceeds trunc_lim_i, the stored frame is the first trunc_lim_i-4 bytes of pad and payload, followed by the CRC. The final descriptor then carries both the truncated bit (2) and the length-violation bit (5).
- R9: When the stored frame length exceeds rx_ctrl_i[31:16], the final descriptor carries the length-violation bit (5) without the truncated bit. A control value of 0x05EE0001 gives a limit of 1518 bytes.
- R10: With shift16_i high at frame start, two zero bytes are written at the head of the first buffer, and the frame length grows by 2.
- R11: After a write-back, the ring index returns to 0 if the wrap bit was set, and otherwise advances by 1.
- R12: After the final write-back, word 0 of the next descriptor is read, and rx_active_o takes its empty bit.
- R13: If a fetched descriptor has its empty bit clear during a frame, nothing more of that frame is written. The rest of the stream is accepted and discarded up to s_last_i, no irq_rxf_o is raised, rx_active_o falls, and the index stays on that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_kick_i | input | 1 | Pulse: re-examine the current descriptor |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| max_buf_i | input | 16 | Maximum bytes per buffer |
| trunc_lim_i | input | 16 | Hard frame length limit, CRC included |
| rx_ctrl_i | input | 32 | Receive control word; bits [31:16] are the soft length limit |
| shift16_i | input | 1 | Insert a two-byte zero pad at the frame head |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Final payload byte of the frame |
| s_ready_o | output | 1 | Stream byte accepted |
| dsc_re_o | output | 1 | Descriptor read; data is returned one cycle later |
| dsc_we_o | output | 1 | Descriptor word write |
| dsc_addr_o | output | AW | Descriptor word byte address |
| dsc_wdata_o | output | 32 | Descriptor write data |
| dsc_rdata_i | input | 32 | Descriptor read data |
| buf_we_o | output | 1 | Buffer byte write |
| buf_addr_o | output | AW | Buffer byte address |
| buf_data_o | output | 8 | Buffer byte data |
| rx_active_o | output | 1 | Receive-active flag |
| irq_rxb_o | output | 1 | Pulse: non-final buffer closed |
| irq_rxf_o | output | 1 | Pulse: final buffer of a frame closed |

## Verification
Two things can land in the same cycle: a buffer filling up, and a CRC byte or a truncation point. A 62-byte payload in 64-byte buffers fills the first buffer with the second CRC byte, so the first write-back is a non-final one while two CRC bytes are still pending. A truncated frame whose cut point falls inside the first buffer shows the CRC following straight after the cut. The scoreboard predicts every buffer byte address and value, and every descriptor write-back word with its interrupt kind. It judges the split by comparing these predictions with what the engine emits, one event at a time.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD0_W, ST_RD1, ST_RD1_W, ST_FILL, ST_WB, ST_DROP
  } fill_st_e;

  typedef enum logic [1:0] {PH_PAD, PH_PAY, PH_CRC} phase_e;

  localparam int DSC_LEN_W = 16;
  localparam int BIT_EMPTY = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_LAST  = 11;
  localparam int BIT_LENV  = 5;
  localparam int BIT_TRUNC = 2;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic [7:0] data_i,
  input  logic [1:0] sel_i,
  output logic [7:0] byte_o
);
  logic [31:0] c_q;
  logic [31:0] fin;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     c_q <= CRC_SEED;
    else if (init_i) c_q <= CRC_SEED;
    else if (upd_i)  c_q <= crc_step(c_q, data_i);
  end

  assign fin = ~c_q;

  // most significant byte goes out first
  always_comb begin
    case (sel_i)
      2'd0:    byte_o = fin[31:24];
      2'd1:    byte_o = fin[23:16];
      2'd2:    byte_o = fin[15:8];
      default: byte_o = fin[7:0];
    endcase
  end

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !upd_i) |=> $stable(c_q)); // R5
endmodule

// File: rtl/rxf_ring_idx.sv
module rxf_ring_idx #(
  parameter int IDX_W = 8,
  parameter int AW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic [AW-1:0]    base_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    w0_addr_o,
  output logic [AW-1:0]    w1_addr_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= wrap_i ? '0 : idx_q + 1'b1;
  end

  assign idx_o     = idx_q;
  assign w0_addr_o = base_i + AW'({idx_q, 3'b000});
  assign w1_addr_o = base_i + AW'({idx_q, 3'b100});

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i) |=> (idx_q == '0)); // R11
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_i) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R11
endmodule

// File: rtl/rx_bd_fill.sv
module rx_bd_fill
  import rxf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_kick_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [15:0]   max_buf_i,
  input  logic [15:0]   trunc_lim_i,
  input  logic [31:0]   rx_ctrl_i,
  input  logic          shift16_i,
  input  logic          s_valid_i,
  input  logic [7:0]    s_data_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          dsc_re_o,
  output logic          dsc_we_o,
  output logic [AW-1:0] dsc_addr_o,
  output logic [31:0]   dsc_wdata_o,
  input  logic [31:0]   dsc_rdata_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    buf_data_o,
  output logic          rx_active_o,
  output logic          irq_rxb_o,
  output logic          irq_rxf_o
);
  localparam int LW = DSC_LEN_W;

  fill_st_e st_q;
  phase_e   ph_q;
  logic            chk_q, pad_q, tr_q, fin_q, act_q;
  logic [1:0]      csel_q;
  logic [LW-1:0]   cnt_q, placed_q;
  logic [15:0]     w0_q;
  logic [AW-1:0]   baddr_q;

  logic            take, emit, crc_upd, crc_init, adv;
  logic            at_trunc, is_final, buf_full_nxt, lenv;
  logic [7:0]      crc_byte;
  logic [15:0]     wb_flags;
  logic [LW:0]     len_tot;
  logic [AW-1:0]   w0_addr, w1_addr;
  logic [IDX_W-1:0] idx;
  logic            unused_ok;

  rxf_crc32 u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .upd_i(crc_upd),
    .data_i(s_data_i), .sel_i(csel_q), .byte_o(crc_byte)
  );

  rxf_ring_idx #(.IDX_W(IDX_W), .AW(AW)) u_ring (
    .clk_i, .rst_ni, .adv_i(adv), .wrap_i(w0_q[BIT_WRAP]), .base_i(ring_base_i),
    .idx_o(idx), .w0_addr_o(w0_addr), .w1_addr_o(w1_addr)
  );

  assign unused_ok    = ^{dsc_rdata_i[31:AW], rx_ctrl_i[15:0], idx};
  assign at_trunc     = (placed_q == trunc_lim_i - 16'd4);
  assign is_final     = (ph_q == PH_CRC) && (csel_q == 2'd3);
  assign buf_full_nxt = (cnt_q + 16'd1 == max_buf_i);
  assign len_tot      = {1'b0, placed_q} + 17'd4;
  assign lenv         = tr_q || (len_tot > {1'b0, rx_ctrl_i[31:16]});

  always_comb begin
    wb_flags = w0_q & ~(16'(1) << BIT_EMPTY) & ~(16'(1) << BIT_LAST)
                    & ~(16'(1) << BIT_LENV) & ~(16'(1) << BIT_TRUNC);
    if (fin_q) begin
      wb_flags[BIT_LAST]  = 1'b1;
      wb_flags[BIT_LENV]  = lenv;
      wb_flags[BIT_TRUNC] = tr_q;
    end
  end

  always_comb begin
    s_ready_o   = 1'b0;
    dsc_re_o    = 1'b0;
    dsc_we_o    = 1'b0;
    dsc_addr_o  = w0_addr;
    dsc_wdata_o = {cnt_q, wb_flags};
    buf_data_o  = 8'h00;
    take = 1'b0; emit = 1'b0; crc_upd = 1'b0; crc_init = 1'b0; adv = 1'b0;
    irq_rxb_o = 1'b0; irq_rxf_o = 1'b0;
    case (st_q)
      ST_IDLE: crc_init = act_q && s_valid_i;
      ST_RD0:  dsc_re_o = 1'b1;
      ST_RD1: begin dsc_re_o = 1'b1; dsc_addr_o = w1_addr; end
      ST_FILL: begin
        case (ph_q)
          PH_PAD: emit = 1'b1;
          PH_PAY: begin
            s_ready_o  = 1'b1;
            take       = s_valid_i;
            emit       = s_valid_i && !at_trunc;
            crc_upd    = s_valid_i;
            buf_data_o = s_data_i;
          end
          default: begin emit = 1'b1; buf_data_o = crc_byte; end
        endcase
      end
      ST_WB: begin
        dsc_we_o  = 1'b1;
        adv       = 1'b1;
        irq_rxf_o = fin_q;
        irq_rxb_o = !fin_q;
      end
      ST_DROP: s_ready_o = 1'b1;
      default: ;
    endcase
  end

  assign buf_we_o    = emit;
  assign buf_addr_o  = baddr_q + AW'(cnt_q);
  assign rx_active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= PH_PAY;
      chk_q <= 1'b0; pad_q <= 1'b0; tr_q <= 1'b0; fin_q <= 1'b0; act_q <= 1'b0;
      csel_q <= '0; cnt_q <= '0; placed_q <= '0; w0_q <= '0; baddr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (act_q && s_valid_i) begin
            ph_q <= shift16_i ? PH_PAD : PH_PAY;
            pad_q <= 1'b0; csel_q <= '0; placed_q <= '0; tr_q <= 1'b0;
            chk_q <= 1'b0; st_q <= ST_RD0;
          end else if (rx_kick_i) begin
            chk_q <= 1'b1; st_q <= ST_RD0;
          end
        end
        ST_RD0: st_q <= ST_RD0_W;
        ST_RD0_W: begin
          w0_q <= dsc_rdata_i[15:0];
          if (chk_q) begin
            act_q <= dsc_rdata_i[BIT_EMPTY];
            st_q  <= ST_IDLE;
          end else if (dsc_rdata_i[BIT_EMPTY]) begin
            st_q <= ST_RD1;
          end else begin
            act_q <= 1'b0;
            st_q  <= (ph_q == PH_CRC) ? ST_IDLE : ST_DROP;
          end
        end
        ST_RD1: st_q <= ST_RD1_W;
        ST_RD1_W: begin
          baddr_q <= dsc_rdata_i[AW-1:0];
          cnt_q   <= '0;
          st_q    <= ST_FILL;
        end
        ST_FILL: begin
          if (emit) begin
            cnt_q <= cnt_q + 16'd1;
            if (ph_q != PH_CRC) placed_q <= placed_q + 16'd1;
          end
          case (ph_q)
            PH_PAD: begin
              pad_q <= 1'b1;
              if (pad_q) ph_q <= PH_PAY;
            end
            PH_PAY: if (take) begin
              if (at_trunc) tr_q <= 1'b1;
              if (s_last_i) ph_q <= PH_CRC;
            end
            default: csel_q <= csel_q + 2'd1;
          endcase
          if (emit && (is_final || buf_full_nxt)) begin
            fin_q <= is_final;
            st_q  <= ST_WB;
          end
        end
        ST_WB: begin
          chk_q <= fin_q;
          st_q  <= ST_RD0;
        end
        ST_DROP: if (s_valid_i && s_last_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUF_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (cnt_q < max_buf_i)); // R4
  AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_rxb_o && irq_rxf_o)); // R7
  AST_TRUNC_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsc_we_o && dsc_wdata_o[BIT_TRUNC]) |-> (placed_q + 16'd4 == trunc_lim_i)); // R8
  AST_ACTIVE_FROM_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD0_W && chk_q) |=> (act_q == $past(dsc_rdata_i[BIT_EMPTY]))); // R12
endmodule

// File: tb/rx_bd_fill_tb_top.sv
module rx_bd_fill_tb_top;
  localparam int AW = 16;
  localparam int NDESC = 6;
  localparam logic [15:0] RING = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_kick = 1'b0, shift16 = 1'b0;
  logic [15:0] mb = 16'd64, tl = 16'd2047;
  logic [31:0] rc = 32'h05EE0001;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0] s_data = 8'h00;
  logic dsc_re, dsc_we, buf_we, rx_active, irq_rxb, irq_rxf;
  logic [AW-1:0] dsc_addr, buf_addr;
  logic [31:0] dsc_wdata, dsc_rdata;
  logic [7:0] buf_data;

  always #10 clk = ~clk;

  rx_bd_fill #(.AW(AW), .IDX_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_kick_i(rx_kick), .ring_base_i(RING),
    .max_buf_i(mb), .trunc_lim_i(tl), .rx_ctrl_i(rc), .shift16_i(shift16),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .dsc_re_o(dsc_re), .dsc_we_o(dsc_we), .dsc_addr_o(dsc_addr),
    .dsc_wdata_o(dsc_wdata), .dsc_rdata_i(dsc_rdata),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data),
    .rx_active_o(rx_active), .irq_rxb_o(irq_rxb), .irq_rxf_o(irq_rxf)
  );

  logic [31:0] dmem [0:255];
  always @(posedge clk) begin
    if (dsc_re) dsc_rdata <= dmem[dsc_addr[9:2]];
    if (dsc_we) dmem[dsc_addr[9:2]] <= dsc_wdata;
  end

  int n_chk = 0, n_fail = 0;
  string cur_req = "R4";
  logic [15:0] exp_wa[$], exp_ba[$];
  logic [31:0] exp_wd[$];
  logic [7:0]  exp_bd[$];
  bit e_flag [NDESC];
  bit w_flag [NDESC];
  int idx_m = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design emits them
  always @(negedge clk) if (rst_n) begin
    if (buf_we) begin
      if (exp_ba.size() == 0) chk(0, cur_req, "unexpected buffer write", {16'h0, buf_addr}, 0);
      else begin
        logic [15:0] a; logic [7:0] d;
        a = exp_ba.pop_front(); d = exp_bd.pop_front();
        chk(buf_addr == a && buf_data == d, cur_req, "buffer byte",
            {buf_addr, 8'h0, buf_data}, {a, 8'h0, d});
      end
    end
    if (dsc_we) begin
      if (exp_wa.size() == 0) chk(0, cur_req, "unexpected write-back", dsc_wdata, 0);
      else begin
        logic [15:0] a; logic [31:0] d;
        a = exp_wa.pop_front(); d = exp_wd.pop_front();
        chk(dsc_addr == a && dsc_wdata == d, cur_req, "write-back word", dsc_wdata, d);
        chk(irq_rxf == d[11] && irq_rxb == !d[11], "R7", "irq kind",
            {30'h0, irq_rxf, irq_rxb}, {30'h0, d[11], !d[11]});
      end
    end else if (irq_rxf || irq_rxb) begin
      chk(0, "R7", "irq without write-back", {30'h0, irq_rxf, irq_rxb}, 0);
    end
  end

  function automatic logic [31:0] ref_crc(input logic [7:0] p[$]);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    foreach (p[i]) begin
      c ^= {24'h0, p[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic arm(input int skip);
    for (int k = 0; k < NDESC; k++) begin
      e_flag[k] = (k != skip);
      w_flag[k] = (k == NDESC - 1);
      dmem[(RING >> 2) + 2*k]     = {16'h0, e_flag[k], 1'b0, w_flag[k], 13'h0};
      dmem[(RING >> 2) + 2*k + 1] = 32'h1000 + 32'(k) * 32'h200;
    end
  endtask

  task automatic kick();
    @(negedge clk); rx_kick = 1'b1;
    @(negedge clk); rx_kick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int n, input int seed, input bit sh, input string req);
    logic [7:0] pl[$], seq[$];
    logic [31:0] crc;
    bit tr, lg, dropped, exp_act;
    int L, off, k, tk;
    logic [15:0] f;
    tr = 0; dropped = 0; cur_req = req;
    for (int i = 0; i < n; i++) pl.push_back(8'((seed + i * 7) & 8'hff));
    if (sh) begin seq.push_back(8'h0); seq.push_back(8'h0); end
    for (int i = 0; i < n; i++) begin
      if (seq.size() < int'(tl) - 4) seq.push_back(pl[i]);
      else tr = 1;
    end
    crc = ref_crc(pl);
    seq.push_back(crc[31:24]); seq.push_back(crc[23:16]);
    seq.push_back(crc[15:8]);  seq.push_back(crc[7:0]);
    L = seq.size();
    lg = tr || (L > int'(rc[31:16]));
    off = 0; k = idx_m;
    while (off < L) begin
      if (!e_flag[k]) begin dropped = 1; break; end
      tk = (L - off < int'(mb)) ? L - off : int'(mb);
      for (int j = 0; j < tk; j++) begin
        exp_ba.push_back(16'h1000 + 16'(k) * 16'h200 + 16'(j));
        exp_bd.push_back(seq[off + j]);
      end
      f = w_flag[k] ? 16'h2000 : 16'h0;
      if (off + tk == L) f |= 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0004 : 16'h0);
      exp_wa.push_back(RING + 16'(k) * 16'd8);
      exp_wd.push_back({16'(tk), f});
      e_flag[k] = 0;
      k = w_flag[k] ? 0 : k + 1;
      off += tk;
    end
    idx_m = k;
    exp_act = dropped ? 1'b0 : e_flag[k];
    shift16 = sh;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_valid = 1'b1; s_data = pl[i]; s_last = (i == n - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    for (int t = 0; t < 300 && (exp_ba.size() + exp_wa.size()) > 0; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(exp_ba.size() == 0 && exp_wa.size() == 0, req, "missing writes",
        32'(exp_ba.size() + exp_wa.size()), 0);
    chk(rx_active == exp_act, req, "rx_active after frame", {31'h0, rx_active}, {31'h0, exp_act});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(!rx_active && !s_ready && !dsc_we && !buf_we && !irq_rxb && !irq_rxf && !dsc_re,
        "R1", "reset outputs", {25'h0, rx_active, s_ready, dsc_we, buf_we, irq_rxb, irq_rxf, dsc_re}, 0);
    rst_n = 1'b1;
    arm(-1);
    // R3: stream offered while inactive is held off
    @(negedge clk); s_valid = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk(!s_ready && !buf_we, "R3", "ready while inactive", {31'h0, s_ready}, 0);
    @(negedge clk); s_valid = 1'b0;
    kick();
    chk(rx_active, "R2", "active after kick", {31'h0, rx_active}, 1);
    frame(100, 3, 0, "R4 R6 R7");             // 64 + 40
    frame(62, 9, 0, "R5 CRC split");          // 64 + 2
    frame(30, 17, 1, "R10 shift pad");        // 36
    tl = 16'd50;
    frame(80, 40, 0, "R8 R11 R12 truncation"); // desc 5, wraps to 0 which is used
    tl = 16'd2047;
    kick();
    chk(!rx_active, "R2", "kick on used descriptor", {31'h0, rx_active}, 0);
    arm(-1); kick();
    chk(rx_active, "R2", "kick after re-arm", {31'h0, rx_active}, 1);
    rc = 32'h00400001;
    frame(61, 77, 0, "R9 soft limit over");   // 65 > 64
    frame(60, 5, 0, "R9 soft limit equal");   // 64, one full buffer
    rc = 32'h05EE0001; mb = 16'd256;
    arm(-1);
    frame(1515, 1, 0, "R9 limit 1518");       // 1519 over six buffers, wraps
    mb = 16'd64;
    arm(4); kick();
    chk(rx_active, "R2", "kick before drop", {31'h0, rx_active}, 1);
    frame(100, 21, 0, "R13 drop");            // desc 3 filled, desc 4 not empty
    repeat (10) @(negedge clk);
    chk(!rx_active && !s_ready, "R13", "quiet after drop", {30'h0, rx_active, s_ready}, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule